// File: doc/BRIEF.md
# Transmit-direction cell receiver for the PHY side of an 8-bit cell bus

This block sits on the PHY side of the transmit half of an 8-bit UTOPIA Level 1 interface. The link-layer master pushes ATM cells one byte per clock while holding its active-low enable low. It marks the first header byte with a start-of-cell strobe. The block gathers each cell into a one-cell store and presents it to local logic as 27 sixteen-bit words on a valid/ready stream. A start-of-cell flag marks the first of those words.

A mode input selects the bus cell length. In 54-byte mode every byte, including the UDF2 byte, travels on the bus. In 53-byte mode the bus omits UDF2, and the block inserts a zero byte straight after the HEC. The user side therefore always sees the same 54-byte layout: four header bytes, HEC, UDF2, then 48 payload bytes. Flow control works a whole cell at a time. The cell-available output drops once a cell is complete and stays low until local logic has taken the last word. Everything runs on the transmit clock, which may run at up to 25 MHz.

Top module: `u1tx_rx_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, cell-available is 1 and user valid is 0.
- R2: A byte is accepted only on a clock edge where the enable input is low. Cycles with the enable high in the middle of a cell neither add nor lose a byte.
- R3: In 54-byte mode (mode input 1), the 54 accepted bytes leave as 27 words. Byte 2k goes in bits 15:8 and byte 2k+1 in bits 7:0 of word k.
- R4: In 53-byte mode (mode input 0), a 0x00 byte is inserted after the fifth accepted byte (the HEC). Word 2 is therefore {HEC, 0x00}, and payload byte j goes to position 6+j.
- R5: User start-of-cell is 1 on word 0 of each cell and 0 on words 1 to 26.
- R6: Cell-available goes low in the cycle after the final byte of a cell is accepted. It stays low while that cell is pending and goes high in the cycle after word 26 is taken.
- R7: Bytes driven while a completed cell is pending are ignored, even when they carry start-of-cell. They change neither the pending words nor the next cell.
- R8: A start-of-cell seen part-way through a cell discards the partial cell and begins a new one with that byte as byte 0.
- R9: Bytes with start-of-cell low that arrive while no cell is in progress are discarded.
- R10: While valid is 1 and ready is 0, valid stays 1 and the word and start-of-cell flag stay unchanged.
- R11: User valid becomes 1 in the cycle after a cell completes, stays 1 until word 26 is taken, and is 0 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_mode54 | input | 1 | 1: 54-byte cells on the bus; 0: 53-byte cells, UDF2 inserted |
| tx_data | input | 8 | Byte from the link-layer master |
| tx_enb_n | input | 1 | Active-low byte enable from the master |
| tx_soc | input | 1 | Marks the first header byte |
| tx_clav | output | 1 | Cell-available: 1 when a whole cell may be sent |
| usr_data | output | 16 | Cell word, earlier byte in bits 15:8 |
| usr_sop | output | 1 | 1 on word 0 of a cell |
| usr_valid | output | 1 | Word on usr_data is valid |
| usr_ready | input | 1 | Local logic takes the word when valid and ready are both 1 |

## Verification
The hardest state to reach is a master that ignores cell-available and keeps driving bytes, including a fresh start-of-cell, while a finished cell sits unread. The bench holds ready low right after a cell completes and drives a burst of such bytes into the pending window. It then drains the cell and checks that it, and the next cell sent, match the reference. Mid-cell restarts, stray bytes while idle, enable gaps and random backpressure are all driven through the same per-cycle reference model.

// File: rtl/u1tx_pkg.sv
package u1tx_pkg;

    // Cell geometry
    localparam int BYTE_W      = 8;
    localparam int WORD_W      = 2 * BYTE_W;
    localparam int HDR_BYTES   = 4;          // generic header bytes before HEC (even, so HEC lands in an upper half)
    localparam int PAY_BYTES   = 48;
    localparam int CELL_BYTES  = HDR_BYTES + 2 + PAY_BYTES;   // header + HEC + UDF2 + payload
    localparam int CELL_WORDS  = CELL_BYTES / 2;
    localparam int HEC_POS     = HDR_BYTES;
    localparam int LAST_POS    = CELL_BYTES - 1;
    localparam int IDX_W       = $clog2(CELL_BYTES);
    localparam int WADDR_W     = $clog2(CELL_WORDS);
    localparam logic [BYTE_W-1:0] UDF2_FILL = '0;

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_BUSY = 1'b1
    } cap_state_t;

    // One byte offered by the bus in a cycle
    typedef struct packed {
        logic              take;
        logic              soc;
        logic [BYTE_W-1:0] data;
    } byte_evt_t;

    // Write request into the cell store, per half-word enables
    typedef struct packed {
        logic               hi_en;
        logic               lo_en;
        logic [WADDR_W-1:0] addr;
        logic [BYTE_W-1:0]  hi;
        logic [BYTE_W-1:0]  lo;
    } word_wr_t;

    function automatic logic [WADDR_W-1:0] word_of(input logic [IDX_W-1:0] pos);
        logic [IDX_W-1:0] half;
        half = pos >> 1;
        return half[WADDR_W-1:0];
    endfunction

    function automatic logic is_last_word(input logic [WADDR_W-1:0] a);
        return a == WADDR_W'(CELL_WORDS - 1);
    endfunction

endpackage

// File: rtl/u1tx_byte_tracker.sv
module u1tx_byte_tracker
    import u1tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mode54,
    input  byte_evt_t evt,
    output word_wr_t  wr,
    output logic      cell_done
);

    cap_state_t       state;
    logic [IDX_W-1:0] idx;
    logic             accept;
    logic [IDX_W-1:0] pos;
    logic [IDX_W-1:0] nxt;

    always_comb begin
        accept    = evt.take && (evt.soc || state == CAP_BUSY);
        pos       = evt.soc ? '0 : idx;
        nxt       = pos + IDX_W'(1);
        wr        = '0;
        wr.addr   = word_of(pos);
        if (accept) begin
            if (!mode54 && pos == IDX_W'(HEC_POS)) begin
                // short cell: HEC and filler UDF2 written together
                wr.hi_en = 1'b1;
                wr.lo_en = 1'b1;
                wr.hi    = evt.data;
                wr.lo    = UDF2_FILL;
                nxt      = pos + IDX_W'(2);
            end else if (!pos[0]) begin
                wr.hi_en = 1'b1;
                wr.hi    = evt.data;
            end else begin
                wr.lo_en = 1'b1;
                wr.lo    = evt.data;
            end
        end
        cell_done = accept && pos == IDX_W'(LAST_POS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CAP_IDLE;
            idx   <= '0;
        end else if (cell_done) begin
            state <= CAP_IDLE;
            idx   <= '0;
        end else if (accept) begin
            state <= CAP_BUSY;
            idx   <= nxt;
        end
    end

endmodule

// File: rtl/u1tx_cell_store.sv
module u1tx_cell_store
    import u1tx_pkg::*;
(
    input  logic               clk,
    input  word_wr_t           wr,
    input  logic [WADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0]  rd_data
);

    logic [BYTE_W-1:0] mem_hi [CELL_WORDS];
    logic [BYTE_W-1:0] mem_lo [CELL_WORDS];

    always_ff @(posedge clk) begin
        if (wr.hi_en) mem_hi[wr.addr] <= wr.hi;
        if (wr.lo_en) mem_lo[wr.addr] <= wr.lo;
    end

    assign rd_data = {mem_hi[rd_addr], mem_lo[rd_addr]};

endmodule

// File: rtl/u1tx_word_reader.sv
module u1tx_word_reader
    import u1tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cell_done,
    input  logic               ready,
    output logic               valid,
    output logic               sop,
    output logic               pending,
    output logic [WADDR_W-1:0] rd_addr
);

    logic               full;
    logic [WADDR_W-1:0] rd;
    logic               fire;

    assign fire = full && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            rd   <= '0;
        end else if (fire) begin
            if (is_last_word(rd)) begin
                full <= 1'b0;
                rd   <= '0;
            end else begin
                rd <= rd + WADDR_W'(1);
            end
        end else if (cell_done) begin
            full <= 1'b1;
            rd   <= '0;
        end
    end

    assign valid   = full;
    assign pending = full;
    assign sop     = full && rd == '0;
    assign rd_addr = rd;

endmodule

// File: rtl/u1tx_rx_top.sv
module u1tx_rx_top
    import u1tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cell_mode54,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_enb_n,
    input  logic              tx_soc,
    output logic              tx_clav,
    output logic [WORD_W-1:0] usr_data,
    output logic              usr_sop,
    output logic              usr_valid,
    input  logic              usr_ready
);

    byte_evt_t          evt;
    word_wr_t           wr;
    logic               cell_done;
    logic               pending;
    logic [WADDR_W-1:0] rd_addr;

    // a pending cell blocks capture entirely
    always_comb begin
        evt.take = !tx_enb_n && !pending;
        evt.soc  = tx_soc;
        evt.data = tx_data;
    end

    u1tx_byte_tracker trk_i (
        .clk       (clk),
        .rst       (rst),
        .mode54    (cell_mode54),
        .evt       (evt),
        .wr        (wr),
        .cell_done (cell_done)
    );

    u1tx_cell_store sto_i (
        .clk     (clk),
        .wr      (wr),
        .rd_addr (rd_addr),
        .rd_data (usr_data)
    );

    u1tx_word_reader rdr_i (
        .clk       (clk),
        .rst       (rst),
        .cell_done (cell_done),
        .ready     (usr_ready),
        .valid     (usr_valid),
        .sop       (usr_sop),
        .pending   (pending),
        .rd_addr   (rd_addr)
    );

    assign tx_clav = !pending;

endmodule

// File: rtl/u1tx_checker.sv
module u1tx_checker
    import u1tx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tx_enb_n,
    input logic              tx_clav,
    input logic [WORD_W-1:0] usr_data,
    input logic              usr_sop,
    input logic              usr_valid,
    input logic              usr_ready
);

    logic               rst_q = 1'b0;
    logic [WADDR_W-1:0] wcnt;
    logic               last_take;

    assign last_take = usr_valid && usr_ready && wcnt == WADDR_W'(CELL_WORDS - 1);

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) wcnt <= '0;
        else if (usr_valid && usr_ready)
            wcnt <= (wcnt == WADDR_W'(CELL_WORDS - 1)) ? '0 : wcnt + WADDR_W'(1);
    end

    // R1: first cycle after reset shows idle outputs
    always_ff @(posedge clk) begin
        if (rst_q && !rst)
            a_r1_reset_idle: assert (tx_clav && !usr_valid);
    end

    // R5
    a_r5_sop_on_word0: assert property (@(posedge clk) disable iff (rst)
        usr_valid |-> (usr_sop == (wcnt == '0)));

    // R6
    a_r6_clav_back_after_last: assert property (@(posedge clk) disable iff (rst)
        last_take |=> tx_clav);

    // R6: a cell can only complete on an accepted byte
    a_r6_done_needs_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(usr_valid) |-> $past(!tx_enb_n));

    // R10
    a_r10_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
        (usr_valid && !usr_ready) |=> (usr_valid && $stable(usr_data) && $stable(usr_sop)));

    // R11
    a_r11_valid_drops: assert property (@(posedge clk) disable iff (rst)
        last_take |=> !usr_valid);

endmodule

bind u1tx_rx_top u1tx_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .tx_enb_n  (tx_enb_n),
    .tx_clav   (tx_clav),
    .usr_data  (usr_data),
    .usr_sop   (usr_sop),
    .usr_valid (usr_valid),
    .usr_ready (usr_ready)
);

// File: tb/u1tx_rx_top_tb_top.sv
module u1tx_rx_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cell_mode54 = 1'b1;
    logic [7:0]  tx_data = '0;
    logic        tx_enb_n = 1'b1;
    logic        tx_soc = 1'b0;
    logic        tx_clav;
    logic [15:0] usr_data;
    logic        usr_sop;
    logic        usr_valid;
    logic        usr_ready = 1'b1;

    int checks = 0;
    int failures = 0;
    bit bp_on = 0;
    bit hold_off = 0;
    int cells_out = 0;

    // reference model state
    bit       m_full = 0;
    int       m_rd = 0;
    bit       m_in = 0;
    byte      cur[$];
    bit [7:0] m_cell [54];

    always #10 clk = ~clk;

    u1tx_rx_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .cell_mode54 (cell_mode54),
        .tx_data     (tx_data),
        .tx_enb_n    (tx_enb_n),
        .tx_soc      (tx_soc),
        .tx_clav     (tx_clav),
        .usr_data    (usr_data),
        .usr_sop     (usr_sop),
        .usr_valid   (usr_valid),
        .usr_ready   (usr_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle reference model
    always @(posedge clk) begin
        if (rst) begin
            m_full = 0; m_rd = 0; m_in = 0; cur.delete();
        end else begin
            automatic bit was_full = m_full;
            if (usr_valid && usr_ready && usr_sop) cells_out++;
            if (m_full && usr_ready) begin
                m_rd++;
                if (m_rd == 27) begin m_full = 0; m_rd = 0; end
            end
            if (!tx_enb_n && !was_full) begin
                if (tx_soc) begin
                    cur.delete(); cur.push_back(tx_data); m_in = 1;
                end else if (m_in) begin
                    cur.push_back(tx_data);
                end
                if (m_in && !cell_mode54 && cur.size() == 5) cur.push_back(8'h00);
                if (cur.size() == 54) begin
                    for (int i = 0; i < 54; i++) m_cell[i] = cur[i];
                    m_full = 1; m_in = 0; cur.delete();
                end
            end
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check(tx_clav == !m_full, "R6 clav", tx_clav, !m_full);
            check(usr_valid == m_full, "R11 valid", usr_valid, m_full);
            if (m_full) begin
                automatic int exp_w = {m_cell[2*m_rd], m_cell[2*m_rd+1]};
                check(usr_data == exp_w[15:0],
                      bp_on ? "R10 data" : (cell_mode54 ? "R3 data" : "R4 data"),
                      usr_data, exp_w);
                check(usr_sop == (m_rd == 0), "R5 sop", usr_sop, m_rd == 0);
            end
        end
    end

    // ready driver
    initial begin
        forever begin
            @(negedge clk);
            if (hold_off) usr_ready = 0;
            else if (bp_on) usr_ready = ($urandom % 3) != 0;
            else usr_ready = 1;
        end
    end

    task automatic wait_clav();
        @(negedge clk);
        while (!tx_clav) @(negedge clk);
    endtask

    task automatic drive_bytes(input int n, input byte base, input bit first_soc, input int gap);
        for (int i = 0; i < n; i++) begin
            tx_enb_n = 0;
            tx_soc   = first_soc && i == 0;
            tx_data  = base + 8'(i);
            @(negedge clk);
            if (gap > 0 && (i % gap) == gap - 1) begin
                tx_enb_n = 1; tx_soc = 0;
                @(negedge clk);
            end
        end
        tx_enb_n = 1; tx_soc = 0;
    endtask

    task automatic send_cell(input byte base, input int gap);
        wait_clav();
        drive_bytes(cell_mode54 ? 54 : 53, base, 1, gap);
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        while (usr_valid) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int base_cnt;
        repeat (3) @(negedge clk);
        check(tx_clav == 1, "R1 clav in reset", tx_clav, 1);
        check(usr_valid == 0, "R1 valid in reset", usr_valid, 0);
        rst = 0;
        @(negedge clk);
        check(tx_clav == 1 && usr_valid == 0, "R1 after reset", {tx_clav, usr_valid}, 2'b10);

        // 54-byte cells, including enable gaps
        base_cnt = cells_out;
        send_cell(8'h10, 0);
        send_cell(8'h40, 3);
        send_cell(8'h80, 7);
        drain();
        check(cells_out - base_cnt == 3, "R2 R3 cells with gaps", cells_out - base_cnt, 3);

        // 53-byte cells with UDF2 insertion
        cell_mode54 = 0;
        base_cnt = cells_out;
        send_cell(8'hA0, 0);
        send_cell(8'h20, 5);
        send_cell(8'hC3, 0);
        drain();
        check(cells_out - base_cnt == 3, "R4 short cells", cells_out - base_cnt, 3);

        // random backpressure, both modes
        bp_on = 1;
        base_cnt = cells_out;
        send_cell(8'h05, 0);
        cell_mode54 = 1;
        wait_clav();
        send_cell(8'h66, 4);
        send_cell(8'h99, 0);
        drain();
        bp_on = 0;
        check(cells_out - base_cnt == 3, "R10 backpressure cells", cells_out - base_cnt, 3);

        // bytes while a cell is pending
        base_cnt = cells_out;
        hold_off = 1;
        send_cell(8'h30, 0);
        @(negedge clk);
        check(tx_clav == 0 && usr_valid == 1, "R6 pending", {tx_clav, usr_valid}, 2'b01);
        drive_bytes(12, 8'hE0, 1, 0);
        drive_bytes(5, 8'hF0, 0, 0);
        hold_off = 0;
        send_cell(8'h51, 0);
        drain();
        check(cells_out - base_cnt == 2, "R7 ignored while pending", cells_out - base_cnt, 2);

        // mid-cell restart
        base_cnt = cells_out;
        wait_clav();
        drive_bytes(20, 8'h70, 1, 0);
        drive_bytes(54, 8'h01, 1, 0);
        drain();
        check(cells_out - base_cnt == 1, "R8 restart", cells_out - base_cnt, 1);

        // stray bytes while idle, in 53-byte mode
        cell_mode54 = 0;
        base_cnt = cells_out;
        wait_clav();
        drive_bytes(9, 8'hB0, 0, 0);
        @(negedge clk);
        check(usr_valid == 0, "R9 idle bytes", usr_valid, 0);
        send_cell(8'h11, 2);
        drain();
        check(cells_out - base_cnt == 1, "R9 one cell", cells_out - base_cnt, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule